// File: doc/BRIEF.md
# Debug Port Mode-Switch Detector

This block sits on the target side of a two-protocol debug port. The port has one combined mode/data line, and the block samples that line on every rising edge of the debug clock. Its job is to decide whether the JTAG TAP logic or the serial-wire protocol engine owns the port. It implements neither protocol. It only watches the line and drives a mode select, a one-cycle pulse when the mode changes, and two reset indications.

A mode change needs a fixed pattern on the line. First the line must be held high for a long run of samples. A 16-bit command must then follow, sent least significant bit first. One command value selects serial-wire operation and the other selects JTAG operation. A command that matches neither value is discarded. A command for the mode that is already active changes nothing.

The same long-high condition is also shown to the protocol logic. In serial-wire mode it appears as a line-reset indication. In JTAG mode it appears as a request to place the TAP in Test-Logic-Reset. An asynchronous active-low reset returns the block to JTAG operation.

Top module: `swDebugModeDetect`

## Requirements
- R1: While `rstN` is low, and at once without a clock edge, `swdMode` is 0 (0 = JTAG, 1 = serial-wire), and `switchPulse`, `lineReset` and `tapReset` are 0.
- R2: Command capture starts only on a low sample that directly follows at least 50 consecutive high samples. That low sample is bit 0 of the command. A command sent after 49 or fewer highs is ignored.
- R3: When the 16 captured bits, assembled LSB first, equal 0xE79E, `swdMode` becomes 1. It changes on the clock edge after the edge that sampled bit 15.
- R4: When the 16 captured bits, assembled LSB first, equal 0xE73C, `swdMode` becomes 0, with the same timing as R3.
- R5: In serial-wire mode, `lineReset` is 1 from the edge that samples the 50th consecutive high until the edge that samples a low. `tapReset` stays 0 during this time.
- R6: In JTAG mode, `tapReset` is 1 from the edge that samples the 50th consecutive high until the edge that samples a low.
- R7: The high-run counter saturates and does not wrap. An indication that has been raised stays at 1 for a high run of any length, and it clears on the first low sample.
- R8: A captured word that matches neither command leaves the mode unchanged. Bits that follow it are ignored until a new run of 50 or more highs has occurred.
- R9: A command for the mode that is already active leaves `swdMode` unchanged and produces no `switchPulse`.
- R10: `switchPulse` is 1 for exactly the one cycle in which `swdMode` takes a new value, and it is 1 at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low power-on/external reset |
| lineIn | input | 1 | Combined mode/data line |
| swdMode | output | 1 | Active protocol: 0 JTAG, 1 serial-wire |
| switchPulse | output | 1 | One-cycle strobe when `swdMode` changes |
| lineReset | output | 1 | Serial-wire line reset condition |
| tapReset | output | 1 | Request to put the TAP in Test-Logic-Reset |

## Verification
The reset indications are due on the same edge that samples the 50th high, and they drop on the edge that samples the first low. The bench therefore checks them 1 ns after that edge, at the 49-high and 50-high boundaries. The mode output and the switch pulse are due one edge after the edge that samples bit 15 of a command. The bench sends one extra high sample after each command, checks both outputs after that edge, and checks after the next edge that the pulse has returned to 0. All inputs change on the falling edge, so each check sees settled register outputs.

// File: rtl/swDetPkg.sv
package swDetPkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_CAPTURE = 1'b1
  } detState_t;

  typedef struct packed {
    logic capStart;  // load the first command bit, restart bit count
    logic capShift;  // shift in the next command bit
  } detStrobe_t;

endpackage

// File: rtl/swDetDatapath.sv
module swDetDatapath
  import swDetPkg::*;
#(
  parameter int HIGH_RUN = 50,
  parameter int CMD_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  detStrobe_t       strb,
  output logic             runDone,
  output logic             wordFull,
  output logic [CMD_W-1:0] capWord
);

  localparam int CNT_W = $clog2(HIGH_RUN + 1);
  localparam int BIT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(HIGH_RUN);
  localparam logic [BIT_W-1:0] BIT_FULL = BIT_W'(CMD_W);

  logic [CNT_W-1:0] highCnt;
  logic [BIT_W-1:0] bitCnt;

  // saturating count of consecutive high samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (!lineIn) begin
      highCnt <= '0;
    end else if (highCnt != RUN_MAX) begin
      highCnt <= highCnt + CNT_W'(1);
    end
  end

  assign runDone = (highCnt == RUN_MAX);

  // LSB-first capture: new bits enter at the top and move down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWord <= '0;
      bitCnt  <= '0;
    end else if (strb.capStart) begin
      capWord <= {lineIn, {(CMD_W-1){1'b0}}};
      bitCnt  <= BIT_W'(1);
    end else if (strb.capShift) begin
      capWord <= {lineIn, capWord[CMD_W-1:1]};
      bitCnt  <= bitCnt + BIT_W'(1);
    end
  end

  assign wordFull = (bitCnt == BIT_FULL);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= RUN_MAX);

  assert_run_needs_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> $past(lineIn));

  assert_bitcnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_FULL);

endmodule

// File: rtl/swDetControl.sv
module swDetControl
  import swDetPkg::*;
#(
  parameter int               CMD_W    = 16,
  parameter logic [CMD_W-1:0] SWD_CMD  = 16'hE79E,
  parameter logic [CMD_W-1:0] JTAG_CMD = 16'hE73C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             runDone,
  input  logic             wordFull,
  input  logic [CMD_W-1:0] capWord,
  output detStrobe_t       strb,
  output logic             swdMode,
  output logic             switchPulse,
  output logic             lineReset,
  output logic             tapReset
);

  detState_t state, nextState;
  logic      nextMode;
  logic      evalNow;

  assign evalNow = (state == ST_CAPTURE) && wordFull;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (!lineIn && runDone) begin
          strb.capStart = 1'b1;
          nextState     = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        if (wordFull) nextState     = ST_IDLE;
        else          strb.capShift = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    nextMode = swdMode;
    if (evalNow) begin
      if (capWord == SWD_CMD)       nextMode = 1'b1;
      else if (capWord == JTAG_CMD) nextMode = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      swdMode     <= 1'b0;
      switchPulse <= 1'b0;
    end else begin
      state       <= nextState;
      swdMode     <= nextMode;
      switchPulse <= (nextMode != swdMode);
    end
  end

  assign lineReset = swdMode & runDone;
  assign tapReset  = ~swdMode & runDone;

  assert_capture_after_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPTURE && $past(state) == ST_IDLE) |-> $past(runDone && !lineIn));

  assert_swd_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swdMode) |-> $past(capWord == SWD_CMD));

  assert_jtag_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swdMode) |-> $past(capWord == JTAG_CMD));

  assert_pulse_has_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    switchPulse |-> (swdMode != $past(swdMode)));

  assert_change_has_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swdMode != $past(swdMode)) |-> switchPulse);

  assert_one_indication_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lineReset, tapReset}));

endmodule

// File: rtl/swDebugModeDetect.sv
module swDebugModeDetect
  import swDetPkg::*;
#(
  parameter int               HIGH_RUN = 50,
  parameter int               CMD_W    = 16,
  parameter logic [CMD_W-1:0] SWD_CMD  = 16'hE79E,
  parameter logic [CMD_W-1:0] JTAG_CMD = 16'hE73C
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic swdMode,
  output logic switchPulse,
  output logic lineReset,
  output logic tapReset
);

  detStrobe_t       strb;
  logic             runDone;
  logic             wordFull;
  logic [CMD_W-1:0] capWord;

  swDetDatapath #(
    .HIGH_RUN (HIGH_RUN),
    .CMD_W    (CMD_W)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .strb     (strb),
    .runDone  (runDone),
    .wordFull (wordFull),
    .capWord  (capWord)
  );

  swDetControl #(
    .CMD_W    (CMD_W),
    .SWD_CMD  (SWD_CMD),
    .JTAG_CMD (JTAG_CMD)
  ) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .runDone     (runDone),
    .wordFull    (wordFull),
    .capWord     (capWord),
    .strb        (strb),
    .swdMode     (swdMode),
    .switchPulse (switchPulse),
    .lineReset   (lineReset),
    .tapReset    (tapReset)
  );

endmodule

// File: tb/swDebugModeDetect_tb_top.sv
module swDebugModeDetect_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b1;
  logic swdMode, switchPulse, lineReset, tapReset;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  swDebugModeDetect dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .swdMode     (swdMode),
    .switchPulse (switchPulse),
    .lineReset   (lineReset),
    .tapReset    (tapReset)
  );

  typedef struct packed {
    logic [7:0]  highs;
    logic [15:0] word;
    logic        expMode;
    logic        expPulse;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{8'd60, 16'hE79E, 1'b1, 1'b1},  // R3 enter serial-wire
    '{8'd60, 16'hE79E, 1'b1, 1'b0},  // R9 same mode again
    '{8'd60, 16'hE73C, 1'b0, 1'b1},  // R4 back to JTAG
    '{8'd49, 16'hE79E, 1'b0, 1'b0},  // R2 run one short
    '{8'd50, 16'hE79E, 1'b1, 1'b1},  // R2 exact run length
    '{8'd60, 16'h1234, 1'b1, 1'b0},  // R8 unknown word
    '{8'd60, 16'hE73C, 1'b0, 1'b1}   // R4 after a discard
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one sample: drive at falling edge, return 1 ns after the rising edge
  task automatic sendBit(input logic b);
    @(negedge clk);
    lineIn = b;
    @(posedge clk);
    #1;
  endtask

  task automatic sendRun(input int n);
    sendBit(1'b0);
    repeat (n) sendBit(1'b1);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 0; i < 16; i++) sendBit(w[i]);
  endtask

  initial begin
    #(100000 * 8);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #20;
    check("R1 reset swdMode", swdMode, 1'b0);
    check("R1 reset switchPulse", switchPulse, 1'b0);
    check("R1 reset lineReset", lineReset, 1'b0);
    check("R1 reset tapReset", tapReset, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      sendRun(int'(VECS[v].highs));
      sendWord(VECS[v].word);
      sendBit(1'b1);
      check($sformatf("R3/R4/R8/R9 vec%0d swdMode", v), swdMode, VECS[v].expMode);
      check($sformatf("R10 vec%0d switchPulse", v), switchPulse, VECS[v].expPulse);
      sendBit(1'b1);
      check($sformatf("R10 vec%0d pulse one cycle", v), switchPulse, 1'b0);
    end

    // R6 Test-Logic-Reset boundary in JTAG mode
    sendRun(49);
    check("R6 tapReset after 49 highs", tapReset, 1'b0);
    sendBit(1'b1);
    check("R6 tapReset after 50 highs", tapReset, 1'b1);
    check("R5 lineReset low in JTAG", lineReset, 1'b0);

    // R7 saturation: long run keeps the indication, low clears it
    repeat (200) sendBit(1'b1);
    check("R7 tapReset after 250 highs", tapReset, 1'b1);
    sendBit(1'b0);
    check("R7 tapReset cleared by low", tapReset, 1'b0);

    // R5 line reset in serial-wire mode
    sendRun(60);
    sendWord(16'hE79E);
    sendBit(1'b1);
    check("R3 swdMode before line reset test", swdMode, 1'b1);
    sendRun(49);
    check("R5 lineReset after 49 highs", lineReset, 1'b0);
    sendBit(1'b1);
    check("R5 lineReset after 50 highs", lineReset, 1'b1);
    check("R5 tapReset low in serial-wire", tapReset, 1'b0);
    sendBit(1'b0);
    check("R5 lineReset cleared by low", lineReset, 1'b0);

    // R8 discard followed at once by a valid command without a new run
    sendRun(60);
    sendWord(16'h1234);
    sendWord(16'hE73C);
    sendBit(1'b1);
    check("R8 swdMode kept after discard", swdMode, 1'b1);
    check("R8 no switchPulse after discard", switchPulse, 1'b0);

    // R1 asynchronous reset between clock edges
    @(negedge clk);
    #1;
    rstN = 1'b0;
    #1;
    check("R1 async reset swdMode", swdMode, 1'b0);
    check("R1 async reset switchPulse", switchPulse, 1'b0);
    check("R1 async reset lineReset", lineReset, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule